// File: doc/BRIEF.md
# Supply Supervisor Reset and Fault Capture

This block sits between two digitized undervoltage comparators and the rest of the chip. When the primary supply is low, the system reset is forced active at once. When the supply comes back, the reset is held for a programmable hold-off time, counted in ticks of a free-running millisecond strobe. Only after that time does the reset release, so that the logic downstream starts on a settled supply. Reset is driven on two pins, one active-high and one active-low.

A second comparator input is passed straight to a second-supply fail output, with no hold-off. This output can warn of a failing raw supply, or it can be combined with the reset elsewhere.

A three-bit sticky fault-cause register is also kept. It records primary undervoltage, second-supply undervoltage and a watchdog-fail pulse. The register comes out of reset cleared. Software arms it by writing all ones. A monitored event then drives its bit to zero, and the bit stays zero until software rewrites it. Software reads the register on a plain byte read port and writes it a whole byte at a time, with no enable sequence.

Top module: `supply_guard`

## Requirements
- R1: While `priLow` is 1, `sysRst` is 1 in the same cycle.
- R2: After `priLow` returns to 0, `sysRst` stays 1 through one idle cycle. It then stays 1 until the hold-off number of `msTick` pulses has been counted, and it falls in the cycle after the last counted pulse.
- R3: The hold-off is selected by `dlySel`: 00 gives 1×UNIT_TICKS, 01 gives 4×UNIT_TICKS, 10 gives 8×UNIT_TICKS and 11 gives 16×UNIT_TICKS ticks. With the default UNIT_TICKS=50 these are 50, 200, 400 and 800 ms. The hold-off counter never reaches 16×UNIT_TICKS.
- R4: If `priLow` is 1 in any cycle of the hold-off count, the count restarts from zero once `priLow` is back to 0.
- R5: `secFail` equals `secLow` in the same cycle, whatever the reset state.
- R6: After `rstN` the fault register reads 0x00. Only bit 7 (primary fail), bit 6 (second-supply fail) and bit 4 (watchdog fail) are stored. All other bits of `regRdData` read 0.
- R7: When `regWrEn` is 1, bits 7, 6 and 4 of `regWrData` are loaded into the register and appear on `regRdData` from the next cycle. No prior enable write is needed.
- R8: Bit 7 is cleared while `priLow` is 1, bit 6 while `secLow` is 1, and bit 4 on a `wdFailPulse`. A cleared bit stays 0 until it is written. If an event and a write happen in the same cycle, the event wins for its bit.
- R9: `sysRstN` is always the inverse of `sysRst`.
- R10: Once released, `sysRst` stays 0 as long as `priLow` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle millisecond strobe |
| priLow | input | 1 | Primary supply below trip level |
| secLow | input | 1 | Second supply below trip level |
| dlySel | input | 2 | Hold-off select |
| wdFailPulse | input | 1 | One-cycle watchdog fail event |
| regWrEn | input | 1 | Fault register write strobe |
| regWrData | input | 8 | Fault register write byte |
| regRdData | output | 8 | Fault register read byte |
| sysRst | output | 1 | System reset, active high |
| sysRstN | output | 1 | System reset, active low |
| secFail | output | 1 | Second-supply fail flag |

## Verification
The bench builds the block with UNIT_TICKS=2, so the four hold-off lengths are 2, 8, 16 and 32 ticks. With these values every select code can be run through to release within a short run. The bench also has room to interrupt a count partway and restart it, and to check the exact release cycle against the last counted tick.

// File: rtl/supGuardPkg.sv
package supGuardPkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } supState_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } ctlStrobe_t;

  localparam int FAULT_BITS = 3;

  // hold-off multiple of the unit for each select code
  function automatic int holdMult(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction

  // register bit position of fault source i (0 primary, 1 second, 2 watchdog)
  function automatic int faultPos(input int i);
    case (i)
      0:       return 7;
      1:       return 6;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/supGuardCtrl.sv
module supGuardCtrl
  import supGuardPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       priLow,
  input  logic       msTick,
  input  logic       lastTick,
  output ctlStrobe_t strobe,
  output logic       rstActive
);

  supState_e st, stNext;

  always_comb begin
    stNext        = st;
    strobe.cntClr = 1'b0;
    strobe.cntInc = 1'b0;
    if (priLow) begin
      stNext        = ST_HOLD;
      strobe.cntClr = 1'b1;
    end else begin
      case (st)
        ST_HOLD: begin
          stNext        = ST_COUNT;
          strobe.cntClr = 1'b1;
        end
        ST_COUNT: begin
          if (msTick) begin
            if (lastTick) begin
              stNext        = ST_RUN;
              strobe.cntClr = 1'b1;
            end else begin
              strobe.cntInc = 1'b1;
            end
          end
        end
        default: stNext = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_COUNT;
    else       st <= stNext;
  end

  assign rstActive = priLow | (st != ST_RUN);

  p_hold_on_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    priLow |=> (st == ST_HOLD));

  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstActive) |-> $past(msTick));

  p_run_stays_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RUN && !priLow) |=> (st == ST_RUN));

endmodule

// File: rtl/supGuardData.sv
module supGuardData
  import supGuardPkg::*;
#(
  parameter int UNIT_TICKS = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic [1:0] dlySel,
  input  logic       priLow,
  input  logic       secLow,
  input  logic       wdFailPulse,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic       lastTick,
  output logic [7:0] faultReg
);

  localparam int MAX_TICKS = 16 * UNIT_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limitM1;

  assign limitM1  = CNT_W'(UNIT_TICKS * holdMult(dlySel) - 1);
  assign lastTick = (cnt >= limitM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc) cnt <= cnt + 1'b1;
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(MAX_TICKS));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> (cnt == '0));

  logic [FAULT_BITS-1:0] evt;
  logic [FAULT_BITS-1:0] faultQ;

  assign evt = {wdFailPulse, secLow, priLow};

  for (genvar g = 0; g < FAULT_BITS; g++) begin : g_fault
    localparam int POS = faultPos(g);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        faultQ[g] <= 1'b0;
      else if (evt[g])  faultQ[g] <= 1'b0;
      else if (regWrEn) faultQ[g] <= regWrData[POS];
    end

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
      (!faultQ[g] && !regWrEn) |=> !faultQ[g]);

    p_event_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      evt[g] |=> !faultQ[g]);
  end

  always_comb begin
    faultReg = '0;
    for (int i = 0; i < FAULT_BITS; i++) faultReg[faultPos(i)] = faultQ[i];
  end

endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supGuardPkg::*;
#(
  parameter int UNIT_TICKS = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       priLow,
  input  logic       secLow,
  input  logic [1:0] dlySel,
  input  logic       wdFailPulse,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       sysRst,
  output logic       sysRstN,
  output logic       secFail
);

  ctlStrobe_t strobe;
  logic       lastTick;
  logic       rstActive;

  supGuardCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .priLow   (priLow),
    .msTick   (msTick),
    .lastTick (lastTick),
    .strobe   (strobe),
    .rstActive(rstActive)
  );

  supGuardData #(.UNIT_TICKS(UNIT_TICKS)) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dlySel     (dlySel),
    .priLow     (priLow),
    .secLow     (secLow),
    .wdFailPulse(wdFailPulse),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .lastTick   (lastTick),
    .faultReg   (regRdData)
  );

  assign sysRst  = rstActive;
  assign sysRstN = ~rstActive;
  assign secFail = secLow;

endmodule

// File: tb/supply_guard_tb_top.sv
module supply_guard_tb_top;

  localparam int UNIT = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0;
  logic       priLow = 1'b0;
  logic       secLow = 1'b0;
  logic [1:0] dlySel = 2'b01;
  logic       wdFailPulse = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sysRst, sysRstN, secFail;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int mSt = 1;     // 0 hold, 1 count, 2 run
  int mTk = 0;
  logic [7:0] mFault = 8'h00;

  always #2.5 clk = ~clk;

  supply_guard #(.UNIT_TICKS(UNIT)) dut_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .priLow(priLow), .secLow(secLow),
    .dlySel(dlySel), .wdFailPulse(wdFailPulse), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sysRst(sysRst),
    .sysRstN(sysRstN), .secFail(secFail)
  );

  function automatic int limOf(input logic [1:0] s);
    case (s)
      2'b00:   return UNIT;
      2'b01:   return 4 * UNIT;
      2'b10:   return 8 * UNIT;
      default: return 16 * UNIT;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    logic [7:0] nf;
    if (!rstN) begin
      mSt = 1; mTk = 0; mFault = 8'h00;
    end else begin
      nf = mFault;
      if (regWrEn) nf = regWrData & 8'hD0;
      if (priLow) nf[7] = 1'b0;
      if (secLow) nf[6] = 1'b0;
      if (wdFailPulse) nf[4] = 1'b0;
      mFault = nf;
      if (priLow) begin
        mSt = 0; mTk = 0;
      end else if (mSt == 0) begin
        mSt = 1; mTk = 0;
      end else if (mSt == 1 && msTick) begin
        mTk++;
        if (mTk >= limOf(dlySel)) begin mSt = 2; mTk = 0; end
      end
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      chk(priLow ? "R1" : (mSt == 2 ? "R10" : "R2"), sysRst,
          (priLow || mSt != 2) ? 1 : 0);
      chk("R9", sysRstN, !sysRst);
      chk("R5", secFail, secLow);
      chk("R8", regRdData, mFault);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) msTick = 1'b1;
      @(negedge clk) msTick = 1'b0;
    end
  endtask

  task automatic brownout();
    @(negedge clk) priLow = 1'b1;
    @(negedge clk) priLow = 1'b0;
    step(1);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) begin regWrEn = 1'b1; regWrData = d; end
    @(negedge clk) regWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    step(2);
    #1;
    chk("R6 reset read", regRdData, 8'h00);
    chk("R2 reset active", sysRst, 1);
    chk("R9 reset active-low", sysRstN, 0);
    @(negedge clk) rstN = 1'b1;

    // power-on hold-off with default select 01
    step(1);
    ticks(4 * UNIT - 1);
    #2 chk("R2 held before last tick", sysRst, 1);
    ticks(1);
    #2 chk("R2 released after last tick", sysRst, 0);

    // each select code
    for (int s = 0; s < 4; s++) begin
      dlySel = 2'(s);
      brownout();
      ticks(limOf(2'(s)) - 1);
      #2 chk("R3 held", sysRst, 1);
      ticks(1);
      #2 chk("R3 release", sysRst, 0);
      step(3);
      #2 chk("R10 stays released", sysRst, 0);
    end

    // restart from zero on interruption
    dlySel = 2'b01;
    brownout();
    ticks(5);
    @(negedge clk) priLow = 1'b1;
    #1 chk("R1 immediate assert", sysRst, 1);
    @(negedge clk) priLow = 1'b0;
    step(1);
    ticks(4 * UNIT - 1);
    #2 chk("R4 restarted count not done", sysRst, 1);
    ticks(1);
    #2 chk("R4 restarted count done", sysRst, 0);

    // second supply flag
    @(negedge clk) secLow = 1'b1;
    #1 chk("R5 secFail follows", secFail, 1);
    chk("R5 no reset from second supply", sysRst, 0);
    @(negedge clk) secLow = 1'b0;

    // fault register
    wr(8'hFF);
    #1 chk("R7 arm reads D0", regRdData, 8'hD0);
    @(negedge clk) wdFailPulse = 1'b1;
    @(negedge clk) wdFailPulse = 1'b0;
    step(3);
    #1 chk("R8 watchdog bit sticky", regRdData, 8'hC0);
    @(negedge clk) secLow = 1'b1;
    @(negedge clk) secLow = 1'b0;
    #1 chk("R8 second bit cleared", regRdData, 8'h80);
    brownout();
    #1 chk("R8 primary bit cleared", regRdData, 8'h00);
    ticks(4 * UNIT);
    @(negedge clk) begin secLow = 1'b1; regWrEn = 1'b1; regWrData = 8'hFF; end
    @(negedge clk) begin secLow = 1'b0; regWrEn = 1'b0; end
    #1 chk("R8 event beats write", regRdData, 8'h90);
    wr(8'h6F);
    #1 chk("R6 unused bits read zero", regRdData, 8'h40);

    step(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule